// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block forms the 16-bit data-memory operand address for a small DSP-style core. In direct mode the address is a 9-bit page number placed above a 7-bit offset carried in the instruction word, so memory is seen as 512 pages of 128 words. In indirect mode the address is the content of one of eight 16-bit auxiliary registers, chosen by a 3-bit pointer. After the address has been presented, an indirect access may step the chosen register by one or by the value held in register 0. All arithmetic is unsigned and wraps at 16 bits.

The pointer keeps a one-deep history buffer. A normal pointer load pushes the old pointer into the buffer. A status-restore operation writes one value into both the buffer and the pointer. A compare operation tests the selected register against register 0 under a 2-bit condition code, then sets or clears a test flag. All control arrives as single-cycle strobes and codes on one clock. The block has no state machine: pointer, buffer, page, flag and register file are plain registers updated on each edge. Address selection and the step and compare units are combinational.

Top module: `aux_addr_gen`

## Requirements
- R1: When `addr_mode` is 0, `mem_addr` equals the page register in bits 15..7 joined with `instr_off` in bits 6..0, with no clock delay.
- R2: A `page_load` strobe writes `page_val` into the page register at the next edge. Without the strobe the page holds its value.
- R3: When `addr_mode` is 1, `mem_addr` equals the auxiliary register selected by the current pointer, with no clock delay.
- R4: An `acc_en` strobe with `addr_mode` 1 updates the selected register at the edge by `upd_op`: 0 none, 1 add one, 2 subtract one, 3 add register 0, 4 subtract register 0, 5 to 7 none. Results wrap modulo 2^16. In direct mode `acc_en` changes no register.
- R5: A `reg_wr` strobe writes `reg_wdata` into the register numbered `reg_wsel`. If the same register is also being updated in that cycle, the write wins.
- R6: A `ptr_load` strobe loads `ptr_val` into the pointer and copies the old pointer into the buffer (`buf_out`).
- R7: A `buf_restore` strobe writes `buf_val` into both the buffer and the pointer, and the old pointer is not copied. If `ptr_load` is also present, the restore wins.
- R8: A `cmp_en` strobe compares the selected register (a) with register 0 (b), both unsigned, under `cmp_code`: 0 a==b, 1 a<b, 2 a>b, 3 a!=b. The flag is set when the condition holds and cleared otherwise. Without the strobe the flag holds.
- R9: An update, write or compare in the same cycle as a pointer change uses the pointer value from before the edge. Register 0 as a step or operand is its value from before the edge.
- R10: Reset clears all auxiliary registers, the page, the pointer, the buffer and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_load | input | 1 | Load page register |
| page_val | input | 9 | New page value |
| instr_off | input | 7 | Offset field from the instruction |
| addr_mode | input | 1 | 0 direct, 1 indirect |
| acc_en | input | 1 | Access strobe enabling post-update |
| upd_op | input | 3 | Post-update code |
| reg_wr | input | 1 | Auxiliary register write strobe |
| reg_wsel | input | 3 | Register number to write |
| reg_wdata | input | 16 | Write data |
| ptr_load | input | 1 | Normal pointer load |
| ptr_val | input | 3 | New pointer value |
| buf_restore | input | 1 | Status restore of buffer and pointer |
| buf_val | input | 3 | Restored value |
| cmp_en | input | 1 | Compare strobe |
| cmp_code | input | 2 | Compare condition |
| mem_addr | output | 16 | Operand address |
| ptr_out | output | 3 | Current pointer |
| buf_out | output | 3 | Pointer history buffer |
| test_flag | output | 1 | Test/control flag |

## Verification
A bad pointer or buffer appears at `ptr_out` or `buf_out` one edge after the strobe that made it. A bad register value stays hidden until an indirect access selects that register, and then it appears on `mem_addr` in the same cycle. A wrong step or a wrong register 0 shows only on a later access, or as a wrong `test_flag` after the next compare. For that reason the bench runs long random sequences against its reference model and compares all outputs on every cycle.

// File: rtl/aag_pkg.sv
package aag_pkg;
    typedef enum logic [2:0] {
        UPD_NONE = 3'd0,
        UPD_INC  = 3'd1,
        UPD_DEC  = 3'd2,
        UPD_ADD0 = 3'd3,
        UPD_SUB0 = 3'd4
    } upd_e;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_LT = 2'd1,
        CMP_GT = 2'd2,
        CMP_NE = 2'd3
    } cmp_e;
endpackage

// File: rtl/aag_step.sv
module aag_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur_val,
    input  logic [WIDTH-1:0] idx_val,
    input  logic [2:0]       op,
    output logic [WIDTH-1:0] next_val
);
    import aag_pkg::*;

    always_comb begin
        case (op)
            UPD_INC:  next_val = cur_val + WIDTH'(1);
            UPD_DEC:  next_val = cur_val - WIDTH'(1);
            UPD_ADD0: next_val = cur_val + idx_val;
            UPD_SUB0: next_val = cur_val - idx_val;
            default:  next_val = cur_val;
        endcase
    end
endmodule

// File: rtl/aag_cmp.sv
module aag_cmp #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic [1:0]       code,
    output logic             hit
);
    import aag_pkg::*;

    always_comb begin
        unique case (cmp_e'(code))
            CMP_EQ: hit = (lhs == rhs);
            CMP_LT: hit = (lhs <  rhs);
            CMP_GT: hit = (lhs >  rhs);
            CMP_NE: hit = (lhs != rhs);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/aag_regfile.sv
module aag_regfile #(
    parameter int NREG  = 8,
    parameter int WIDTH = 16,
    parameter int SELW  = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SELW-1:0]            wr_sel,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       upd_en,
    input  logic [SELW-1:0]            upd_sel,
    input  logic [WIDTH-1:0]           upd_data,
    output logic [NREG-1:0][WIDTH-1:0] regs_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_en && wr_sel == SELW'(g)) begin
                regs_q[g] <= wr_data;
            end else if (upd_en && upd_sel == SELW'(g)) begin
                regs_q[g] <= upd_data;
            end
        end

        // R5
        reg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SELW'(g)) |=> regs_q[g] == $past(wr_data));

        // R4
        reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_sel == SELW'(g)) && !(upd_en && upd_sel == SELW'(g)))
            |=> $stable(regs_q[g]));
    end
endmodule

// File: rtl/aux_addr_gen.sv
module aux_addr_gen #(
    parameter int AWIDTH = 16,
    parameter int NREG   = 8,
    parameter int PGW    = 9,
    parameter int OFFW   = AWIDTH - PGW,
    parameter int SELW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_load,
    input  logic [PGW-1:0]    page_val,
    input  logic [OFFW-1:0]   instr_off,
    input  logic              addr_mode,
    input  logic              acc_en,
    input  logic [2:0]        upd_op,
    input  logic              reg_wr,
    input  logic [SELW-1:0]   reg_wsel,
    input  logic [AWIDTH-1:0] reg_wdata,
    input  logic              ptr_load,
    input  logic [SELW-1:0]   ptr_val,
    input  logic              buf_restore,
    input  logic [SELW-1:0]   buf_val,
    input  logic              cmp_en,
    input  logic [1:0]        cmp_code,
    output logic [AWIDTH-1:0] mem_addr,
    output logic [SELW-1:0]   ptr_out,
    output logic [SELW-1:0]   buf_out,
    output logic              test_flag
);
    import aag_pkg::*;

    logic [PGW-1:0]              page_q;
    logic [SELW-1:0]             ptr_q;
    logic [SELW-1:0]             buf_q;
    logic                        flag_q;
    logic [NREG-1:0][AWIDTH-1:0] ar_q;
    logic [AWIDTH-1:0]           sel_val;
    logic [AWIDTH-1:0]           step_val;
    logic                        cmp_hit;
    logic                        upd_fire;

    assign sel_val  = ar_q[ptr_q];
    assign upd_fire = acc_en && addr_mode;

    aag_step #(.WIDTH(AWIDTH)) i_step (
        .cur_val  (sel_val),
        .idx_val  (ar_q[0]),
        .op       (upd_op),
        .next_val (step_val)
    );

    aag_cmp #(.WIDTH(AWIDTH)) i_cmp (
        .lhs  (sel_val),
        .rhs  (ar_q[0]),
        .code (cmp_code),
        .hit  (cmp_hit)
    );

    aag_regfile #(.NREG(NREG), .WIDTH(AWIDTH), .SELW(SELW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_sel   (reg_wsel),
        .wr_data  (reg_wdata),
        .upd_en   (upd_fire),
        .upd_sel  (ptr_q),
        .upd_data (step_val),
        .regs_q   (ar_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (page_load) begin
            page_q <= page_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            buf_q <= '0;
        end else if (buf_restore) begin
            ptr_q <= buf_val;
            buf_q <= buf_val;
        end else if (ptr_load) begin
            ptr_q <= ptr_val;
            buf_q <= ptr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (cmp_en) begin
            flag_q <= cmp_hit;
        end
    end

    always_comb begin
        if (addr_mode) begin
            mem_addr = sel_val;
        end else begin
            mem_addr = {page_q, instr_off};
        end
    end

    assign ptr_out   = ptr_q;
    assign buf_out   = buf_q;
    assign test_flag = flag_q;

    // R6
    buf_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && !buf_restore) |=> (buf_q == $past(ptr_q)) && (ptr_q == $past(ptr_val)));

    // R7
    restore_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_restore |=> (ptr_q == buf_q) && (buf_q == $past(buf_val)));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_load && !buf_restore) |=> $stable(ptr_q) && $stable(buf_q));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(flag_q));

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !page_load |=> $stable(page_q));

    // R4
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && upd_op == 3'd1 && !(reg_wr && reg_wsel == ptr_q))
        |=> ar_q[$past(ptr_q)] == $past(sel_val) + AWIDTH'(1));
endmodule

// File: tb/test_aux_addr_gen.sv
module test_aux_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_load = 0;
    logic [8:0]  page_val = '0;
    logic [6:0]  instr_off = '0;
    logic        addr_mode = 0;
    logic        acc_en = 0;
    logic [2:0]  upd_op = '0;
    logic        reg_wr = 0;
    logic [2:0]  reg_wsel = '0;
    logic [15:0] reg_wdata = '0;
    logic        ptr_load = 0;
    logic [2:0]  ptr_val = '0;
    logic        buf_restore = 0;
    logic [2:0]  buf_val = '0;
    logic        cmp_en = 0;
    logic [1:0]  cmp_code = '0;
    logic [15:0] mem_addr;
    logic [2:0]  ptr_out, buf_out;
    logic        test_flag;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_ar [8];
    logic [8:0]  m_page;
    logic [2:0]  m_ptr, m_buf;
    logic        m_flag;

    always #2 clk = ~clk;

    aux_addr_gen i_aux_addr_gen (
        .clk(clk), .rst_n(rst_n), .page_load(page_load), .page_val(page_val),
        .instr_off(instr_off), .addr_mode(addr_mode), .acc_en(acc_en), .upd_op(upd_op),
        .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
        .ptr_load(ptr_load), .ptr_val(ptr_val), .buf_restore(buf_restore), .buf_val(buf_val),
        .cmp_en(cmp_en), .cmp_code(cmp_code), .mem_addr(mem_addr),
        .ptr_out(ptr_out), .buf_out(buf_out), .test_flag(test_flag)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        page_load = 0; acc_en = 0; reg_wr = 0; ptr_load = 0;
        buf_restore = 0; cmp_en = 0;
    endtask

    // one cycle: check address now, step model at the edge, check state after it
    task automatic cycle(string tag);
        logic [15:0] ea, a, b, t;
        logic [15:0] n_ar [8];
        logic [2:0] n_ptr, n_buf;
        logic n_flag;
        #1;
        ea = addr_mode ? m_ar[m_ptr] : {m_page, instr_off};
        chk({tag, " R1/R3 addr"}, mem_addr, ea);
        @(posedge clk);
        n_ar = m_ar; n_ptr = m_ptr; n_buf = m_buf; n_flag = m_flag;
        a = m_ar[m_ptr]; b = m_ar[0];
        if (cmp_en) begin
            case (cmp_code)
                2'd0: n_flag = (a == b);
                2'd1: n_flag = (a < b);
                2'd2: n_flag = (a > b);
                default: n_flag = (a != b);
            endcase
        end
        if (acc_en && addr_mode) begin
            case (upd_op)
                3'd1: t = a + 16'd1;
                3'd2: t = a - 16'd1;
                3'd3: t = a + b;
                3'd4: t = a - b;
                default: t = a;
            endcase
            n_ar[m_ptr] = t;
        end
        if (reg_wr) n_ar[reg_wsel] = reg_wdata;
        if (buf_restore) begin
            n_ptr = buf_val; n_buf = buf_val;
        end else if (ptr_load) begin
            n_buf = m_ptr; n_ptr = ptr_val;
        end
        if (page_load) m_page = page_val;
        m_ar = n_ar; m_ptr = n_ptr; m_buf = n_buf; m_flag = n_flag;
        @(negedge clk);
        chk({tag, " R6/R7 ptr"}, 16'(ptr_out), 16'(m_ptr));
        chk({tag, " R6/R7 buf"}, 16'(buf_out), 16'(m_buf));
        chk({tag, " R8 flag"}, 16'(test_flag), 16'(m_flag));
        clear_in();
    endtask

    task automatic wr_reg(string tag, int r, logic [15:0] v);
        reg_wr = 1; reg_wsel = 3'(r); reg_wdata = v; cycle(tag);
    endtask

    task automatic read_all(string tag);
        for (int r = 0; r < 8; r++) begin
            ptr_load = 1; ptr_val = 3'(r); cycle(tag);
            addr_mode = 1; cycle(tag);
            addr_mode = 0;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_ar[i] = '0;
        m_page = '0; m_ptr = '0; m_buf = '0; m_flag = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 ptr", 16'(ptr_out), 16'd0);
        chk("R10 buf", 16'(buf_out), 16'd0);
        chk("R10 flag", 16'(test_flag), 16'd0);
        instr_off = 7'h55; #1;
        chk("R10 page", mem_addr, 16'h0055);
        rst_n = 1;
        @(negedge clk);
        read_all("R10 regs");

        // R1 R2: direct addressing with several pages
        page_load = 1; page_val = 9'h1FF; instr_off = 7'h7F; cycle("R2 load");
        instr_off = 7'h00; cycle("R1 low");
        page_load = 1; page_val = 9'h0A5; instr_off = 7'h3C; cycle("R2 load2");
        instr_off = 7'h41; cycle("R1 mid");

        // R5 and R3
        for (int r = 0; r < 8; r++) wr_reg("R5 write", r, 16'h1000 * 16'(r) + 16'(r));
        read_all("R3 read");

        // R4: updates and wrap
        wr_reg("R5 w0", 0, 16'h0010);
        wr_reg("R5 w3", 3, 16'h0000);
        ptr_load = 1; ptr_val = 3; cycle("R6 p3");
        addr_mode = 1;
        acc_en = 1; upd_op = 3'd2; cycle("R4 dec wrap");
        acc_en = 1; upd_op = 3'd1; cycle("R4 inc wrap");
        acc_en = 1; upd_op = 3'd3; cycle("R4 add0");
        acc_en = 1; upd_op = 3'd4; cycle("R4 sub0");
        acc_en = 1; upd_op = 3'd4; cycle("R4 sub0 wrap");
        acc_en = 1; upd_op = 3'd5; cycle("R4 code5");
        acc_en = 1; upd_op = 3'd7; cycle("R4 code7");
        cycle("R4 observe");
        addr_mode = 0; acc_en = 1; upd_op = 3'd1; cycle("R4 direct noupd");
        addr_mode = 1; cycle("R4 direct noupd obs");
        // R5: write beats update
        acc_en = 1; upd_op = 3'd1; reg_wr = 1; reg_wsel = 3; reg_wdata = 16'hBEEF;
        cycle("R5 priority");
        cycle("R5 priority obs");

        // R6 R7 R9
        ptr_load = 1; ptr_val = 5; cycle("R6 load5");
        ptr_load = 1; ptr_val = 1; cycle("R6 load1");
        buf_restore = 1; buf_val = 6; cycle("R7 restore");
        buf_restore = 1; buf_val = 2; ptr_load = 1; ptr_val = 7; cycle("R7 priority");
        acc_en = 1; upd_op = 3'd1; ptr_load = 1; ptr_val = 4; cycle("R9 access+load");
        ptr_load = 1; ptr_val = 2; cycle("R9 back");
        cycle("R9 obs");

        // R8: compares, unsigned
        wr_reg("R8 w0", 0, 16'h0001);
        wr_reg("R8 w2", 2, 16'h8000);
        for (int c = 0; c < 4; c++) begin
            cmp_en = 1; cmp_code = 2'(c); cycle("R8 gt case");
            cycle("R8 hold");
        end
        wr_reg("R8 w2b", 2, 16'h0001);
        for (int c = 0; c < 4; c++) begin
            cmp_en = 1; cmp_code = 2'(c); cycle("R8 eq case");
        end
        ptr_load = 1; ptr_val = 0; cycle("R8 sel0");
        wr_reg("R8 w0b", 0, 16'h0000);
        ptr_load = 1; ptr_val = 5; cycle("R8 sel5");
        cmp_en = 1; cmp_code = 2'd1; cycle("R8 lt");

        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            addr_mode = rv[0];
            acc_en = rv[1];
            upd_op = rv[4:2];
            reg_wr = (rv[7:5] == 0);
            reg_wsel = rv[10:8];
            reg_wdata = (rv[11]) ? 16'($urandom) : {15'd0, rv[12]};
            ptr_load = (rv[14:13] == 0);
            ptr_val = rv[17:15];
            buf_restore = (rv[20:18] == 0);
            buf_val = rv[23:21];
            cmp_en = rv[24];
            cmp_code = rv[26:25];
            page_load = (rv[29:27] == 0);
            page_val = 9'($urandom);
            instr_off = 7'($urandom);
            cycle("R4 R9 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule